// File: doc/BRIEF.md
# Approximate Ripple-Carry Adder with Reduced Carry Cells

This block is a purely combinational N-bit ripple-carry adder. Each bit position is a full-adder cell whose sum is always the exact three-input XOR. Its carry may be chosen from a small set of simplified functions. Each simplified carry is wrong at exactly one of the eight input combinations of the cell. That one wrong entry is chosen so that the majority function (three AND terms and two ORs) collapses to a single AND and a single OR. Under uniform inputs, such a cell errs on 1/8 of its input combinations.

The designer picks a variant per bit through the parameter `CELL_CFG`, which holds a 3-bit code for each bit. Bit i uses field `CELL_CFG[3*i +: 3]`. The intended use is to mark as wrong the input combinations that the application's data rarely produces. Cells with low arithmetic weight, or with skewed operand statistics, can then be simplified at almost no cost in output error. Only flips that shrink the logic are offered. Flips at 000 and 111 would grow the carry logic, so no code selects them. Choosing the codes is left to the integrator.

A cell's inputs form a minterm index `{a, b, cin}`, with a as the most significant bit, running from 000 to 111. The default configuration uses codes 1 to 7 on bits 0 to 6 in that order. Bits 7 to 15 are exact.

Top module: `aprx_rca_adder`

## Requirements
- R1: Every bit of `sum_out` equals `op_a[i] ^ op_b[i] ^ c_i`, where `c_i` is the carry entering bit i. `c_0` is `carry_in`, and `c_(i+1)` is the carry produced by cell i.
- R2: `carry_out` is the carry produced by the most significant cell, so {carry_out, sum_out} is the ripple of the configured cells over all WIDTH bits.
- R3: Code 0 gives an exact cell whose carry is the majority of a, b and cin. With every code at 0, {carry_out, sum_out} equals op_a + op_b + carry_in.
- R4: Code 1 sets the carry to `cin | (a & b)`. It differs from the majority only at minterm 001, where it outputs 1.
- R5: Code 2 sets the carry to `b | (a & cin)`. It differs from the majority only at minterm 010, where it outputs 1.
- R6: Code 3 sets the carry to `a | (b & cin)`. It differs from the majority only at minterm 100, where it outputs 1.
- R7: Code 4 sets the carry to `a & (b | cin)`. It differs from the majority only at minterm 011, where it outputs 0.
- R8: Code 5 sets the carry to `b & (a | cin)`. It differs from the majority only at minterm 101, where it outputs 0.
- R9: Code 6 sets the carry to `cin & (a | b)`. It differs from the majority only at minterm 110, where it outputs 0.
- R10: Code 7 is reserved and behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is an approximate cell that meets its own flipped minterm and sends a wrong carry into the exact bits above. The error is only visible at the top output when that wrong carry has to travel through a long stretch of propagate bits. The stimulus therefore sweeps all eight minterms on a standalone cell of each variant. It also adds directed operands in which one low cell sees its flipped minterm while every higher bit has a differing from b, so the wrong carry ripples all the way to `carry_out`. Random operands make up the rest of the stimulus and yield a relative error magnitude figure.

// File: rtl/aprx_pkg.sv
package aprx_pkg;
  localparam int CODE_W = 3;

  // Carry variant codes; each flipped variant errs at one minterm {a,b,cin}.
  typedef enum logic [CODE_W-1:0] {
    CELL_EXACT   = 3'd0,
    CELL_SET_001 = 3'd1,
    CELL_SET_010 = 3'd2,
    CELL_SET_100 = 3'd3,
    CELL_CLR_011 = 3'd4,
    CELL_CLR_101 = 3'd5,
    CELL_CLR_110 = 3'd6,
    CELL_RSVD    = 3'd7
  } cell_kind_e;
endpackage

// File: rtl/aprx_carry_cell.sv
module aprx_carry_cell
  import aprx_pkg::*;
#(
  parameter int KIND = 0
) (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic carry_o
);
  generate
    case (KIND)
      int'(CELL_SET_001): begin : g_set001
        assign carry_o = c_i | (a_i & b_i);
      end
      int'(CELL_SET_010): begin : g_set010
        assign carry_o = b_i | (a_i & c_i);
      end
      int'(CELL_SET_100): begin : g_set100
        assign carry_o = a_i | (b_i & c_i);
      end
      int'(CELL_CLR_011): begin : g_clr011
        assign carry_o = a_i & (b_i | c_i);
      end
      int'(CELL_CLR_101): begin : g_clr101
        assign carry_o = b_i & (a_i | c_i);
      end
      int'(CELL_CLR_110): begin : g_clr110
        assign carry_o = c_i & (a_i | b_i);
      end
      default: begin : g_exact
        assign carry_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
      end
    endcase
  endgenerate
endmodule

// File: rtl/aprx_fa_cell.sv
module aprx_fa_cell #(
  parameter int KIND = 0
) (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic carry_o
);
  assign sum_o = a_i ^ b_i ^ c_i;

  aprx_carry_cell #(.KIND(KIND)) carry_u (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/aprx_rca_adder.sv
module aprx_rca_adder
  import aprx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter logic [CODE_W*WIDTH-1:0] CELL_CFG = {{(CODE_W*WIDTH-21){1'b0}}, 21'o7654321}
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  logic [WIDTH:0] carry_w;

  assign carry_w[0] = carry_in;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int K = int'(CELL_CFG[CODE_W*i +: CODE_W]);
      aprx_fa_cell #(.KIND(K)) fa_u (
        .a_i     (op_a[i]),
        .b_i     (op_b[i]),
        .c_i     (carry_w[i]),
        .sum_o   (sum_out[i]),
        .carry_o (carry_w[i+1])
      );
    end
  endgenerate

  assign carry_out = carry_w[WIDTH];
endmodule

// File: rtl/aprx_rca_adder_chk.sv
module aprx_rca_adder_chk
  import aprx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter logic [CODE_W*WIDTH-1:0] CELL_CFG = '0
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic [WIDTH:0]   chain
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      localparam int K = int'(CELL_CFG[CODE_W*i +: CODE_W]);
      logic [2:0] m;
      logic       maj;
      assign m   = {op_a[i], op_b[i], chain[i]};
      assign maj = (m[2] & m[1]) | (m[2] & m[0]) | (m[1] & m[0]);

      always_comb begin
        if (!$isunknown({m, sum_out[i]}))
          assert_sum_xor_R1: assert (sum_out[i] == ^m);
      end

      case (K)
        1: begin : g_k1
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_set001_R4: assert ((chain[i+1] != maj) == (m == 3'b001));
        end
        2: begin : g_k2
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_set010_R5: assert ((chain[i+1] != maj) == (m == 3'b010));
        end
        3: begin : g_k3
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_set100_R6: assert ((chain[i+1] != maj) == (m == 3'b100));
        end
        4: begin : g_k4
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_clr011_R7: assert ((chain[i+1] != maj) == (m == 3'b011));
        end
        5: begin : g_k5
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_clr101_R8: assert ((chain[i+1] != maj) == (m == 3'b101));
        end
        6: begin : g_k6
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_clr110_R9: assert ((chain[i+1] != maj) == (m == 3'b110));
        end
        7: begin : g_k7
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_rsvd_exact_R10: assert (chain[i+1] == maj);
        end
        default: begin : g_k0
          always_comb if (!$isunknown({m, chain[i+1]}))
            assert_exact_maj_R3: assert (chain[i+1] == maj);
        end
      endcase
    end
  endgenerate

  always_comb begin
    if (!$isunknown({carry_in, chain[0]}))
      assert_chain_base_R2: assert (chain[0] == carry_in);
    if (!$isunknown({carry_out, chain[WIDTH]}))
      assert_chain_top_R2: assert (carry_out == chain[WIDTH]);
  end
endmodule

bind aprx_rca_adder aprx_rca_adder_chk #(
  .WIDTH    (WIDTH),
  .CELL_CFG (CELL_CFG)
) chk_i (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out),
  .chain     (carry_w)
);

// File: tb/aprx_rca_adder_tb_top.sv
module aprx_rca_adder_tb_top;
  localparam int W = 16;
  localparam logic [3*W-1:0] CFG = {{(3*W-21){1'b0}}, 21'o7654321};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_d, sum_e;
  logic         co_d, co_e;

  aprx_rca_adder #(.WIDTH(W), .CELL_CFG(CFG)) dut_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_d), .carry_out(co_d));

  aprx_rca_adder #(.WIDTH(W), .CELL_CFG('0)) exact_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_e), .carry_out(co_e));

  logic [2:0] cell_m = '0;
  logic [7:0] cs, cc;
  generate
    for (genvar k = 0; k < 8; k++) begin : g_cell
      aprx_fa_cell #(.KIND(k)) cell_u (
        .a_i(cell_m[2]), .b_i(cell_m[1]), .c_i(cell_m[0]),
        .sum_o(cs[k]), .carry_o(cc[k]));
    end
  endgenerate

  // Minterm flipped by each code; 8 means none.
  function automatic int flip_of(int kind);
    case (kind)
      1: return 1;  2: return 2;  3: return 4;
      4: return 3;  5: return 5;  6: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic string tag_of(int kind);
    case (kind)
      1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9";
      7: return "R10"; default: return "R3";
    endcase
  endfunction

  function automatic logic exp_carry(int kind, logic [2:0] m);
    logic maj;
    maj = (m[2] & m[1]) | (m[2] & m[0]) | (m[1] & m[0]);
    return maj ^ (flip_of(kind) == int'(m));
  endfunction

  function automatic logic [W:0] model(logic [3*W-1:0] cfg, logic [W-1:0] a,
                                       logic [W-1:0] b, logic c);
    logic [W:0] r;
    logic cy;
    cy = c;
    for (int i = 0; i < W; i++) begin
      r[i] = a[i] ^ b[i] ^ cy;
      cy   = exp_carry(int'(cfg[3*i +: 3]), {a[i], b[i], cy});
    end
    r[W] = cy;
    return r;
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  real rem_sum = 0.0;
  int  rem_n = 0;

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c);
    logic [W:0] ex;
    @(posedge clk); #2;
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    ex = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    // R1 R2 R4..R10: approximate adder against ripple of configured cells
    check("R1/R2 approx adder", {co_d, sum_d}, model(CFG, a, b, c));
    // R3: all-exact adder against true sum
    check("R3 exact adder", {co_e, sum_e}, ex);
    if (ex != 0) begin
      rem_sum += ((ex > {co_d, sum_d}) ? real'(ex - {co_d, sum_d})
                                       : real'({co_d, sum_d} - ex)) / real'(ex);
      rem_n++;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // reset state: zero operands give zero result
    @(negedge clk);
    check("R3 zero operands", {co_e, sum_e}, '0);
    check("R1 zero operands", {co_d, sum_d}, model(CFG, '0, '0, 1'b0));

    // per-cell sweep of all minterms, every variant
    for (int m = 0; m < 8; m++) begin
      @(posedge clk); #2;
      cell_m = 3'(m);
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        check({tag_of(k), " cell carry"}, {{W{1'b0}}, cc[k]},
              {{W{1'b0}}, exp_carry(k, 3'(m))});
        check("R1 cell sum", {{W{1'b0}}, cs[k]}, {{W{1'b0}}, ^(3'(m))});
      end
    end

    // directed corners
    apply('0, '0, 1'b1);
    apply('1, '1, 1'b1);
    apply('1, '0, 1'b1);                  // long propagate, R2 carry_out
    apply(16'hFFFE, 16'h0000, 1'b1);      // bit0 sees 001 (R4), ripples up
    apply(16'hFFFC, 16'h0002, 1'b0);      // bit1 sees 010 (R5)
    apply(16'hFFF8, 16'h0000, 1'b0);      // bit6 code7 exact path R10
    apply(16'h0041, 16'h0041, 1'b1);      // bit6 generates under code 7
    apply(16'h0008, 16'h0008, 1'b0);      // bit3 sees 110 region (R7 cell)
    apply(16'h0020, 16'h0000, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);

    for (int t = 0; t < 400; t++)
      apply(W'($urandom), W'($urandom), 1'($urandom));

    if (rem_n > 0)
      $display("relative error magnitude: %f", rem_sum / real'(rem_n));
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule